// File: doc/BRIEF.md
# Multiplierless transposed-form FIR filter

This block is a fully parallel FIR filter with four fixed taps, built in transposed form. Each cycle in which `valid_i` is high, one signed input sample is accepted. One cycle later the block presents one signed output sample at full precision. Cycles in which `valid_i` is low leave the filter untouched. Taps are numbered from 0, and tap 0 weights the newest accepted sample. The tap weights are h0 = 3, h1 = 7, h2 = 14 and h3 = -21.

The filter uses no general multiplier. A single combinational network of shifts, adders and subtractors forms every tap product from the current sample, and it builds each shared odd term only once. The term 3x is made first and is reused to make 21x. The term 7x is reused, shifted, to make 14x. The sign of the negative tap is applied by its chain adder, which subtracts. A register sits after each tap adder, so the longest path is the product network plus one adder.

Top module: `fir_mcm_tf`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), `valid_o` is 0, `data_o` is 0 and every stored partial sum is cleared.
- R2: `valid_o` equals the value `valid_i` had one clock earlier.
- R3: After an accepted sample x[n], the next cycle shows `data_o` = 3·x[n] + 7·x[n-1] + 14·x[n-2] − 21·x[n-3]. Here n counts accepted samples only, and samples accepted before the last reset count as zero.
- R4: In a cycle with `valid_i` low, `data_i` is ignored, `data_o` keeps its value and the sample history does not advance.
- R5: `data_o` is DATA_W+COEF_W+2 bits wide and two's complement signed. It is exact for every input sequence, including the most negative value (−2^(DATA_W−1)) and alternating extremes, and it never wraps.
- R6: Every tap product comes from one shift-add network with exactly three add/sub operations. Each network output equals |h_k|·x for the current sample.
- R7: A single accepted sample of 1 followed by accepted zeros gives the output sequence 3, 7, 14, −21, 0.
- R8: A reset applied in the middle of a stream discards all history. The first output after reset depends only on samples accepted after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | DATA_W | Signed input sample |
| valid_o | output | 1 | Output sample strobe, one cycle after valid_i |
| data_o | output | DATA_W+COEF_W+2 | Signed full-precision filter output |

## Verification
The unit impulse exposes each tap weight separately, in order, so a swapped, mis-shifted or wrongly signed tap shows at its own position. A constant step exposes the running coefficient sums, which include the sum that cancels to zero (7+14−21). That cancellation hides no error only if every tap is exact. Random signed streams with idle gaps separate the cycles that accept a sample from the cycles that hold. Runs of the most negative value and of alternating extremes push the sum to the edge of its width, where a narrow accumulator or a missing sign extension would wrap.

// File: rtl/fir_mcm_pkg.sv
package fir_mcm_pkg;
  localparam int N_TAPS = 4;
  localparam int GROW_W = $clog2(N_TAPS);
  // magnitude delivered by the product network, tap 0 = newest sample
  localparam int TAP_MAG [N_TAPS] = '{3, 7, 14, 21};
  // bit k set: tap k subtracts its product (negative coefficient)
  localparam logic [N_TAPS-1:0] TAP_SUB = 4'b1000;
endpackage

// File: rtl/fir_mcm_net.sv
module fir_mcm_net
  import fir_mcm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PROD_W = 24
) (
  input  logic signed [DATA_W-1:0]             x_i,
  output logic        [N_TAPS-1:0][PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] xs;
  logic signed [PROD_W-1:0] t3, t7, t21;

  assign xs = PROD_W'(x_i);

  // three add/sub operations; odd terms 3 and 7 are shared
  assign t3  = (xs <<< 1) + xs;
  assign t7  = (xs <<< 3) - xs;
  assign t21 = (t3 <<< 3) - t3;

  assign prod_o[0] = t3;
  assign prod_o[1] = t7;
  assign prod_o[2] = t7 <<< 1;
  assign prod_o[3] = t21;
endmodule

// File: rtl/fir_tap_stage.sv
module fir_tap_stage #(
  parameter int   PROD_W = 24,
  parameter int   ACC_W  = 26,
  parameter logic SUB    = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic        [PROD_W-1:0] prod_i,
  input  logic signed [ACC_W-1:0]  tail_i,
  output logic signed [ACC_W-1:0]  acc_o
);
  logic signed [ACC_W-1:0] prod_ext, sum;

  assign prod_ext = ACC_W'($signed(prod_i));

  generate
    if (SUB) begin : g_sub
      assign sum = tail_i - prod_ext;
    end else begin : g_add
      assign sum = tail_i + prod_ext;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_o <= '0;
    else if (en_i) acc_o <= sum;
  end
endmodule

// File: rtl/fir_mcm_tf.sv
module fir_mcm_tf
  import fir_mcm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 8,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int ACC_W  = DATA_W + COEF_W + GROW_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic                     valid_o,
  output logic signed [ACC_W-1:0]  data_o
);
  logic [N_TAPS-1:0][PROD_W-1:0] mcm_prod;
  logic signed [ACC_W-1:0]       acc [N_TAPS+1];
  logic                          valid_q;

  fir_mcm_net #(
    .DATA_W(DATA_W),
    .PROD_W(PROD_W)
  ) u_net (
    .x_i   (data_i),
    .prod_o(mcm_prod)
  );

  assign acc[N_TAPS] = '0;

  // acc[k] holds the partial sum entering tap k-1; acc[0] is the output
  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    fir_tap_stage #(
      .PROD_W(PROD_W),
      .ACC_W (ACC_W),
      .SUB   (TAP_SUB[k])
    ) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (valid_i),
      .prod_i(mcm_prod[k]),
      .tail_i(acc[k+1]),
      .acc_o (acc[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o = valid_q;
  assign data_o  = acc[0];
endmodule

// File: rtl/fir_mcm_tf_chk.sv
module fir_mcm_tf_chk
  import fir_mcm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 8,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int ACC_W  = DATA_W + COEF_W + GROW_W
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          valid_i,
  input logic signed [DATA_W-1:0]      data_i,
  input logic                          valid_o,
  input logic signed [ACC_W-1:0]       data_o,
  input logic [N_TAPS-1:0][PROD_W-1:0] prod_i
);
  localparam longint LIM = 45 * (longint'(1) << (DATA_W - 1));

  logic primed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r1: assert (!valid_o && data_o == '0);
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> (valid_o == $past(valid_i)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && !$past(valid_i)) |-> $stable(data_o));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (longint'(data_o) <= LIM) && (longint'(data_o) >= -LIM));

  for (genvar k = 0; k < N_TAPS; k++) begin : g_prod
    p_mcm_prod_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      longint'($signed(prod_i[k])) == longint'(TAP_MAG[k]) * longint'(data_i));
  end
endmodule

bind fir_mcm_tf fir_mcm_tf_chk #(
  .DATA_W(DATA_W),
  .COEF_W(COEF_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .data_i (data_i),
  .valid_o(valid_o),
  .data_o (data_o),
  .prod_i (mcm_prod)
);

// File: tb/fir_mcm_tf_test.sv
module fir_mcm_tf_test;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int OW = DW + CW + 2;
  localparam int NT = 12;
  localparam longint H [4] = '{3, 7, 14, -21};
  localparam int TBL_X [NT] = '{1, 0, 0, 0, 0, 100, 100, 100, 100, 100, -5, 0};
  localparam int TBL_Y [NT] = '{3, 7, 14, -21, 0, 300, 1000, 2400, 300, 300, -15, -735};

  logic                 clk = 1'b0;
  logic                 rst_ni;
  logic                 valid_i;
  logic signed [DW-1:0] data_i;
  logic                 valid_o;
  logic signed [OW-1:0] data_o;

  int     n_chk = 0;
  int     n_bad = 0;
  bit     done  = 1'b0;
  longint hist [4];
  longint exp_y;
  bit     exp_v;

  always #5 clk = ~clk;

  fir_mcm_tf #(.DATA_W(DW), .COEF_W(CW)) uut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (data_i),
    .valid_o(valid_o),
    .data_o (data_o)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 4; i++) hist[i] = 0;
    exp_y = 0;
    exp_v = 1'b0;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic apply(input logic signed [DW-1:0] x, input bit v);
    valid_i = v;
    data_i  = x;
    exp_v   = v;
    if (v) begin
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = longint'(x);
      exp_y = 0;
      for (int i = 0; i < 4; i++) exp_y += H[i] * hist[i];
    end
    @(negedge clk);
  endtask

  task automatic check_out(input string tag);
    check(tag, longint'(data_o), exp_y);
    check({tag, " valid R2"}, longint'(valid_o), longint'(exp_v));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    rst_ni  = 1'b1;
    valid_i = 1'b0;
    data_i  = '0;
    clear_model();
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset data", longint'(data_o), 0);
    check("R1 reset valid", longint'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table: impulse (R7) then step and tail (R3, R6)
    for (int i = 0; i < NT; i++) begin
      apply(DW'(TBL_X[i]), 1'b1);
      check(i < 5 ? "R7 impulse" : "R3 R6 step", longint'(data_o), longint'(TBL_Y[i]));
      check("R2 valid", longint'(valid_o), 1);
    end

    // idle gaps: output holds, history frozen (R4)
    for (int i = 0; i < 3; i++) begin
      apply(DW'($urandom()), 1'b0);
      check_out("R4 gap hold");
    end
    apply(16'sd9, 1'b1);
    check_out("R4 after gap");

    // extremes (R5)
    for (int i = 0; i < 5; i++) begin
      apply(16'sh8000, 1'b1);
      check_out("R5 most negative");
    end
    for (int i = 0; i < 6; i++) begin
      apply((i % 2 == 0) ? 16'sh7fff : 16'sh8000, 1'b1);
      check_out("R5 alternating");
    end

    // random stream with gaps (R3, R4)
    for (int i = 0; i < 60; i++) begin
      apply(DW'($urandom()), ($urandom_range(0, 3) != 0));
      check_out("R3 random");
    end

    // mid-stream reset discards history (R8, R1)
    apply(16'sd1234, 1'b1);
    rst_ni = 1'b0;
    #1;
    check("R1 mid reset data", longint'(data_o), 0);
    check("R1 mid reset valid", longint'(valid_o), 0);
    clear_model();
    valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    apply(16'sd1, 1'b1);
    check_out("R8 first after reset");
    apply(16'sd0, 1'b1);
    check_out("R8 second after reset");

    finish_run();
  end
endmodule